// File: doc/BRIEF.md
# Picture-in-Picture Window Compositor

The compositor keeps a reduced copy of a second video source and lays it over the main picture in one of four corners. Its write side takes 6-bit luma and colour-difference samples from the sub-picture path with a line strobe and a field strobe. It thins them by three or by four in both directions, depending on the size mode. The kept samples are packed into an on-chip field store. Every store word covers six luma pixels and carries one B-Y and one R-Y value. A freeze input stops all writes, so the last stored picture stays on screen.

The read side counts main-picture pixels from the rising edge of the horizontal sync input. It counts lines from the first horizontal sync that follows a rising vertical sync. For each pixel it decides whether the pixel falls inside the window picture, inside a 2-pixel by 2-line border around it, or outside. It then drives the stored samples, or the border luma, together with a mix select for the downstream switch. All logic runs in one pixel clock domain. With the default sizes the store uses 29 words per line of 48 bits for 69 lines, which is 96,048 bits and fits within 96 kbit.

Top module: `pip_compositor`

## Requirements
- R1: After reset, and until the first rising edge of `vd` has been followed by a rising edge of `hd`, `mix_sel` is low and `pip_y`, `pip_u` and `pip_v` are zero.
- R2: With `size_sel`=0 the write side keeps every third sample of every third line, starting at sample 0 of the first line after a field strobe. The window is W9 pixels by H9 lines. Window pixel (column c, row r) shows the Y of input sample 3c on input line 3r.
- R3: With `size_sel`=1 the write side keeps every fourth sample of every fourth line. The window is W16 pixels by H16 lines. Window pixel (c, r) shows the Y of input sample 4c on input line 4r.
- R4: Window columns are grouped six at a time. The group starting at kept column 6g shows, on all its pixels, the B-Y of kept column 6g and the R-Y of kept column 6g+3. In a final group narrower than four columns, the R-Y comes from the last kept column of that group.
- R5: `corner` bit 0 selects the right side and bit 1 selects the bottom. The outer box, which is the window plus 2 pixels and 2 lines on each side, starts at pixel H_MRG or H_ACT-H_MRG-boxwidth, and at line V_MRG or V_ACT-V_MRG-boxheight.
- R6: A pixel in the box but outside the window is a border pixel. With `frame_on`=1 a border pixel gives `mix_sel`=1, `pip_y`=`frame_luma`, and B-Y and R-Y zero. With `frame_on`=0 it gives `mix_sel`=0 and all outputs zero. Pixels outside the box always give `mix_sel`=0 and zeros.
- R7: While `freeze`=1 no sample is written to the store, and the display keeps showing the earlier content.
- R8: With `disp_en`=0 the outputs are `mix_sel`=0 and all zeros.
- R9: The pixel counter restarts at each rising edge of `hd`. If `hd` is first sampled high at clock edge k, the output for pixel h is present after edge k+1+h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low reset |
| size_sel | input | 1 | 0: one-ninth window, 1: one-sixteenth window |
| corner | input | 2 | Bit 0 right, bit 1 bottom |
| frame_on | input | 1 | Border enable |
| frame_luma | input | 6 | Border luma level |
| freeze | input | 1 | Stops store writes |
| wr_vs | input | 1 | Sub-picture field strobe (rising edge) |
| wr_hs | input | 1 | Sub-picture line strobe (rising edge) |
| wr_valid | input | 1 | Sub-picture sample valid |
| wr_y | input | 6 | Sub-picture luma sample |
| wr_u | input | 6 | Sub-picture B-Y sample |
| wr_v | input | 6 | Sub-picture R-Y sample |
| hd | input | 1 | Main horizontal sync, rising edge used |
| vd | input | 1 | Main vertical sync, active high |
| disp_en | input | 1 | Window display enable |
| mix_sel | output | 1 | Selects the window output over the main picture |
| pip_y | output | 6 | Window luma |
| pip_u | output | 6 | Window B-Y |
| pip_v | output | 6 | Window R-Y |

## Verification
The hardest case to reach from the ports is the short last column group in the one-ninth mode. Its R-Y must come from a sample that is not at a slot-3 position, and that sample is only reachable after a full, thinned line has been written. The bench gives the window a width that is not a multiple of six and writes whole fields of distinct values. It then scans every main-picture pixel, so the short group is compared on every window row. A field written while frozen uses new values, and the next full display scan must still match the earlier field.

// File: rtl/pip_compositor.sv
`timescale 1ns/1ps
module pip_compositor #(
  parameter int PW    = 6,
  parameter int W9    = 171,
  parameter int H9    = 69,
  parameter int W16   = 128,
  parameter int H16   = 52,
  parameter int H_ACT = 760,
  parameter int V_ACT = 240,
  parameter int H_MRG = 40,
  parameter int V_MRG = 16,
  parameter int BRD   = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          size_sel,
  input  logic [1:0]    corner,
  input  logic          frame_on,
  input  logic [PW-1:0] frame_luma,
  input  logic          freeze,
  input  logic          wr_vs,
  input  logic          wr_hs,
  input  logic          wr_valid,
  input  logic [PW-1:0] wr_y,
  input  logic [PW-1:0] wr_u,
  input  logic [PW-1:0] wr_v,
  input  logic          hd,
  input  logic          vd,
  input  logic          disp_en,
  output logic          mix_sel,
  output logic [PW-1:0] pip_y,
  output logic [PW-1:0] pip_u,
  output logic [PW-1:0] pip_v
);
  localparam int SLOTS = 6;
  localparam int WPL   = (W9 + SLOTS - 1) / SLOTS;
  localparam int DEPTH = WPL * H9;
  localparam int AW    = $clog2(DEPTH);
  localparam int DW    = PW * (SLOTS + 2);
  localparam int XW    = $clog2(W9 + 1);
  localparam int YW    = $clog2(H9 + 1);
  localparam int WW    = $clog2(WPL + 1);
  localparam int HW    = $clog2(H_ACT + 1);
  localparam int VW    = $clog2(V_ACT + 1);

  logic [DW-1:0] mem [DEPTH];

  // write side
  logic hs_q, vs_q, vs_pend;
  logic [1:0] sph, lph;
  logic [XW-1:0] kx;
  logic [YW-1:0] ky;
  logic [2:0] s6;
  logic [WW-1:0] wx;
  logic [PW*SLOTS-1:0] ybuf, ynew;
  logic [PW-1:0] ubuf, vbuf, unew, vnew;

  wire hs_rise = wr_hs & ~hs_q;
  wire vs_rise = wr_vs & ~vs_q;
  wire [1:0] dec_last = size_sel ? 2'd3 : 2'd2;
  wire [XW-1:0] wcur = size_sel ? XW'(W16) : XW'(W9);
  wire [YW-1:0] hcur = size_sel ? YW'(H16) : YW'(H9);
  wire keep = wr_valid && !hs_rise && lph == 2'd0 && ky < hcur && sph == 2'd0 && kx < wcur;
  wire last = (kx == wcur - XW'(1));
  wire we = keep && !freeze && (s6 == 3'd5 || last);
  wire [AW-1:0] waddr = AW'(ky) * AW'(WPL) + AW'(wx);

  always_comb begin
    ynew = ybuf;
    ynew[s6*PW +: PW] = wr_y;
    unew = (s6 == 3'd0) ? wr_u : ubuf;
    vnew = (s6 == 3'd3 || (last && s6 < 3'd3)) ? wr_v : vbuf;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      hs_q <= 1'b0; vs_q <= 1'b0; vs_pend <= 1'b0;
      sph <= '0; lph <= '0; kx <= '0; ky <= YW'(H9); s6 <= '0; wx <= '0;
      ybuf <= '0; ubuf <= '0; vbuf <= '0;
    end else begin
      hs_q <= wr_hs;
      vs_q <= wr_vs;
      if (vs_rise) vs_pend <= 1'b1;
      if (hs_rise) begin
        sph <= '0; kx <= '0; s6 <= '0; wx <= '0;
        if (vs_pend || vs_rise) begin
          lph <= '0; ky <= '0; vs_pend <= 1'b0;
        end else if (lph == dec_last) begin
          lph <= '0;
          if (ky != YW'(H9)) ky <= ky + YW'(1);
        end else lph <= lph + 2'd1;
      end else if (wr_valid) begin
        sph <= (sph == dec_last) ? 2'd0 : sph + 2'd1;
        if (keep) begin
          kx <= kx + XW'(1);
          ybuf <= ynew; ubuf <= unew; vbuf <= vnew;
          if (s6 == 3'd5) begin
            s6 <= '0; wx <= wx + WW'(1);
          end else s6 <= s6 + 3'd1;
        end
      end
    end

  always_ff @(posedge clk)
    if (we) mem[waddr] <= {vnew, unew, ynew};

  AST_WADDR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> int'(waddr) < DEPTH); // R2

  // read side
  logic hd_q, vd_q, vd_pend;
  logic [HW-1:0] hcnt;
  logic [VW-1:0] vcnt;
  logic [2:0] rslot;
  logic [WW-1:0] rword;

  wire hd_rise = hd & ~hd_q;
  wire vd_rise = vd & ~vd_q;
  wire [HW-1:0] wpic = size_sel ? HW'(W16) : HW'(W9);
  wire [VW-1:0] hpic = size_sel ? VW'(H16) : VW'(H9);
  wire [HW-1:0] bx = corner[0] ? HW'(H_ACT - H_MRG - 2*BRD) - wpic : HW'(H_MRG);
  wire [VW-1:0] by = corner[1] ? VW'(V_ACT - V_MRG - 2*BRD) - hpic : VW'(V_MRG);
  wire [HW-1:0] x0 = bx + HW'(BRD);
  wire [VW-1:0] y0 = by + VW'(BRD);
  wire col_box = hcnt >= bx && hcnt < x0 + wpic + HW'(BRD);
  wire row_box = vcnt >= by && vcnt < y0 + hpic + VW'(BRD);
  wire col_pic = hcnt >= x0 && hcnt < x0 + wpic;
  wire row_pic = vcnt >= y0 && vcnt < y0 + hpic;
  wire pic = col_pic && row_pic;
  wire border = col_box && row_box && !pic;
  wire [AW-1:0] raddr = AW'(vcnt - y0) * AW'(WPL) + AW'(rword);
  wire [DW-1:0] rd = mem[raddr];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      hd_q <= 1'b0; vd_q <= 1'b0; vd_pend <= 1'b0;
      hcnt <= HW'(H_ACT); vcnt <= VW'(V_ACT); rslot <= '0; rword <= '0;
    end else begin
      hd_q <= hd;
      vd_q <= vd;
      if (vd_rise) vd_pend <= 1'b1;
      if (hd_rise) begin
        hcnt <= '0; rslot <= '0; rword <= '0;
        if (vd_pend || vd_rise) begin
          vcnt <= '0; vd_pend <= 1'b0;
        end else if (vcnt != VW'(V_ACT)) vcnt <= vcnt + VW'(1);
      end else begin
        if (hcnt != HW'(H_ACT)) hcnt <= hcnt + HW'(1);
        if (col_pic) begin
          if (rslot == 3'd5) begin
            rslot <= '0; rword <= rword + WW'(1);
          end else rslot <= rslot + 3'd1;
        end
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      mix_sel <= 1'b0; pip_y <= '0; pip_u <= '0; pip_v <= '0;
    end else begin
      mix_sel <= disp_en && (pic || (frame_on && border));
      pip_y <= !disp_en ? '0 : pic ? rd[rslot*PW +: PW] : (frame_on && border) ? frame_luma : '0;
      pip_u <= (disp_en && pic) ? rd[SLOTS*PW +: PW] : '0;
      pip_v <= (disp_en && pic) ? rd[(SLOTS+1)*PW +: PW] : '0;
    end

  AST_FREEZE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(freeze) && $stable(raddr)) |-> $stable(rd)); // R7
  AST_BORDER_NO_CHROMA: assert property (@(posedge clk) disable iff (!rst_n)
    (mix_sel && !$past(pic)) |-> (pip_u == '0 && pip_v == '0)); // R6
  AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(disp_en) |-> (!mix_sel && pip_y == '0 && pip_u == '0 && pip_v == '0)); // R8
endmodule

// File: tb/pip_compositor_tb.sv
`timescale 1ns/1ps
module pip_compositor_tb;
  localparam int W9 = 9, H9 = 4, W16 = 6, H16 = 3;
  localparam int H_ACT = 40, V_ACT = 20, H_MRG = 3, V_MRG = 2;
  localparam int LT = 44, NS = 30;

  logic clk = 0, rst_n = 0;
  logic size_sel = 0, frame_on = 0, freeze = 0, disp_en = 0;
  logic [1:0] corner = 0;
  logic [5:0] frame_luma = 6'd45;
  logic wr_vs = 0, wr_hs = 0, wr_valid = 0, hd = 0, vd = 0;
  logic [5:0] wr_y = 0, wr_u = 0, wr_v = 0;
  logic mix_sel;
  logic [5:0] pip_y, pip_u, pip_v;

  int total = 0, bad = 0;
  int my [H9][W9];
  int mu [H9][2];
  int mv [H9][2];
  logic [19:0] exp_q [$];
  string tag_q [$];

  always #2 clk = ~clk;

  pip_compositor #(.W9(W9), .H9(H9), .W16(W16), .H16(H16), .H_ACT(H_ACT),
    .V_ACT(V_ACT), .H_MRG(H_MRG), .V_MRG(V_MRG)) u_dut (
    .clk(clk), .rst_n(rst_n), .size_sel(size_sel), .corner(corner), .frame_on(frame_on),
    .frame_luma(frame_luma), .freeze(freeze), .wr_vs(wr_vs), .wr_hs(wr_hs),
    .wr_valid(wr_valid), .wr_y(wr_y), .wr_u(wr_u), .wr_v(wr_v), .hd(hd), .vd(vd),
    .disp_en(disp_en), .mix_sel(mix_sel), .pip_y(pip_y), .pip_u(pip_u), .pip_v(pip_v));

  task automatic check(input string tg, input int act, input int ex);
    total++;
    if (act != ex) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tg, act, ex, $time);
    end
  endtask

  // monitor: pops expectations pushed by the driver in the same cycle
  always @(negedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      logic [19:0] e;
      string tg;
      e = exp_q.pop_front();
      tg = tag_q.pop_front();
      check(tg, {mix_sel, pip_y}, e[18:12]);
      check(e[19] ? "R4" : tg, {pip_u, pip_v}, e[11:0]);
    end
  end

  task automatic write_field(input int seed);
    int d, hh, w;
    d = size_sel ? 4 : 3;
    hh = size_sel ? H16 : H9;
    w = size_sel ? W16 : W9;
    @(negedge clk) wr_vs = 1;
    @(negedge clk) wr_vs = 0;
    for (int L = 0; L < d*hh; L++) begin
      @(negedge clk) wr_hs = 1;
      @(negedge clk) wr_hs = 0;
      for (int s = 0; s < NS; s++) begin
        int yv, uv, vv;
        yv = (L*7 + s*3 + seed*11) & 63;
        uv = (L*5 + s + seed*3) & 63;
        vv = (L + s*5 + seed*13) & 63;
        wr_valid = 1; wr_y = 6'(yv); wr_u = 6'(uv); wr_v = 6'(vv);
        if (!freeze && L % d == 0 && s % d == 0 && s / d < w) begin
          int ky, kx;
          ky = L / d; kx = s / d;
          my[ky][kx] = yv;
          if (kx % 6 == 0) mu[ky][kx/6] = uv;
          if (kx % 6 == 3 || (kx == w-1 && kx % 6 < 3)) mv[ky][kx/6] = vv;
        end
        @(negedge clk);
      end
      wr_valid = 0;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic run_line(input int l, input bit live, input string tp, input string tout);
    int w, hh, bx, by, x0, y0;
    w = size_sel ? W16 : W9;
    hh = size_sel ? H16 : H9;
    bx = corner[0] ? H_ACT - H_MRG - w - 4 : H_MRG;
    by = corner[1] ? V_ACT - V_MRG - hh - 4 : V_MRG;
    x0 = bx + 2; y0 = by + 2;
    @(negedge clk) hd = 1;
    @(negedge clk) hd = 0;
    for (int h = 0; h < LT; h++) begin
      logic [19:0] e;
      string tg;
      bit box, pic;
      @(negedge clk);
      e = '0; tg = tout;
      box = h >= bx && h < bx + w + 4 && l >= by && l < by + hh + 4;
      pic = h >= x0 && h < x0 + w && l >= y0 && l < y0 + hh;
      if (live && disp_en) begin
        if (pic) begin
          e = {1'b1, 1'b1, 6'(my[l-y0][h-x0]), 6'(mu[l-y0][(h-x0)/6]), 6'(mv[l-y0][(h-x0)/6])};
          tg = tp;
        end else if (box) begin
          tg = "R6";
          if (frame_on) e = {1'b0, 1'b1, frame_luma, 12'd0};
        end
      end
      exp_q.push_back(e);
      tag_q.push_back(tg);
    end
  endtask

  task automatic run_field(input string tp, input string tout);
    @(negedge clk) vd = 1;
    @(negedge clk) vd = 0;
    for (int l = 0; l < V_ACT; l++) run_line(l, 1, tp, tout);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", {mix_sel, pip_y, pip_u, pip_v}, 0);
    rst_n = 1;
    @(negedge clk);
    check("R1", {mix_sel, pip_y, pip_u, pip_v}, 0);
    disp_en = 1; frame_on = 1;
    // R1 no window before a field start on the main side
    for (int l = 0; l < 3; l++) run_line(l, 0, "R1", "R1");
    // R2 one-ninth mode, top-left, border on; R9 timing outside the box
    write_field(1);
    run_field("R2", "R9");
    // R5 bottom-right corner
    corner = 2'd3;
    run_field("R2", "R5");
    // R6 border off, bottom-left
    corner = 2'd2; frame_on = 0;
    run_field("R2", "R6");
    // R8 display disabled, top-right
    corner = 2'd1; frame_on = 1; disp_en = 0;
    run_field("R8", "R8");
    // R7 frozen write leaves the earlier picture
    disp_en = 1; corner = 2'd0; freeze = 1;
    write_field(2);
    run_field("R7", "R7");
    // R3 one-sixteenth mode
    freeze = 0; size_sel = 1; corner = 2'd1;
    write_field(3);
    run_field("R3", "R5");
    corner = 2'd2;
    run_field("R3", "R5");
    repeat (4) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule